// File: doc/BRIEF.md
# Two-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the requests arriving at its left and right ports. Each port presents an enable, a write strobe and an address. When both ports are enabled on the same address, the arbiter gives that location to one port. It drives an active-low busy flag to the other port and blocks that port's write before it reaches the array. Ownership follows arrival order. A port that was already enabled on the address in the previous clock cycle beats a port that has just moved onto it. When both ports arrive in the same cycle, a fixed or alternating tie-break decides.

Several arbiters can be ganged to build a wider word. One device runs as master: it computes the busy flags and drives them out. The others run as slaves. A slave does not drive its own arbitration result. It takes the master's busy flags on dedicated inputs and uses them only to gate writes. It lets a write through only after the incoming flag has been high for two consecutive clock samples.

The busy flags and write strobes are combinational from the current request and the registered state. They are valid in the same cycle as the request they answer.

Top module: `port_collision_arb`

## Requirements
- R1: A collision exists only while both enables are 1 and all address bits are equal. In every other cycle, both busy outputs are 1 (inactive) in that same cycle.
- R2: A port that was enabled on the same address in the previous cycle wins over a port that is new to the address. The newcomer's busy output goes to 0 in the first cycle of the collision.
- R3: A collision is recognised both when an already enabled port changes its address to match the other port and when an enable goes to 1 while the addresses already match.
- R4: In master mode (`mode_master` = 1), exactly one busy output is 0 in every collision cycle.
- R5: A write strobe output is 1 only when its port's enable and write request are both 1 and that port is not held off. In master mode, a port is held off when its busy output is 0.
- R6: While a collision continues without a break, the owning port does not change, and neither busy output changes.
- R7: When both ports start a collision in the same cycle, the left port wins if `TIE_ALTERNATE` = 0. If `TIE_ALTERNATE` = 1, the first tie after reset goes to the left port, and each further tie goes to the opposite port from the previous tie.
- R8: In slave mode (`mode_master` = 0), both busy outputs stay at 1 even during a collision.
- R9: In slave mode, a port's write strobe is 0 while that port's busy input is 0.
- R10: In slave mode, a write is let through only if the busy input is 1 now and was also 1 at the previous clock edge. After reset, that earlier sample counts as 0.
- R11: In master mode, the busy inputs have no effect on the write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_master | input | 1 | 1 = master (drive busy), 0 = slave (accept busy) |
| left_en | input | 1 | Left port access enable |
| left_we | input | 1 | Left port write request |
| left_addr | input | AW (12) | Left port address |
| right_en | input | 1 | Right port access enable |
| right_we | input | 1 | Right port write request |
| right_addr | input | AW (12) | Right port address |
| left_busy_in_n | input | 1 | Busy from master for the left port, active low (slave mode) |
| right_busy_in_n | input | 1 | Busy from master for the right port, active low (slave mode) |
| left_busy_n | output | 1 | Busy to the left port, active low |
| right_busy_n | output | 1 | Busy to the right port, active low |
| left_wr_ok | output | 1 | Gated write strobe toward the array, left port |
| right_wr_ok | output | 1 | Gated write strobe toward the array, right port |

## Verification
The hardest case to reach is the tie: both ports must land on the same address in the same cycle. In the alternating variant, the tie history also decides which port wins next. The stimulus brings both ports to idle and then enables them together on one address, twice in a row. A second instance built with alternating priority runs on the same inputs, so the default and alternating outcomes can be compared on the same pair of ties. The slave settling window is reached by lowering one busy input for one cycle during a write and then checking the strobe on the two cycles after the input returns high.

// File: rtl/pca_pkg.sv
package pca_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   tie_right;
    } res_state_t;
endpackage

// File: rtl/pca_port_track.sv
module pca_port_track #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          held
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.en   = en;
        trk_d.addr = addr;
        held       = en && trk_q.en && (trk_q.addr == addr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/pca_resolve.sv
module pca_resolve
    import pca_pkg::*;
#(
    parameter bit TIE_ALTERNATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic held_l,
    input  logic held_r,
    output logic lose_l,
    output logic lose_r
);
    res_state_t st_d, st_q;
    owner_e     win;
    logic       tie;

    always_comb begin
        st_d = st_q;
        win  = OWN_NONE;
        tie  = 1'b0;
        if (match) begin
            if (st_q.owner != OWN_NONE) begin
                win = st_q.owner;
            end else if (held_l && !held_r) begin
                win = OWN_LEFT;
            end else if (held_r && !held_l) begin
                win = OWN_RIGHT;
            end else begin
                tie = 1'b1;
                win = (TIE_ALTERNATE && st_q.tie_right) ? OWN_RIGHT : OWN_LEFT;
            end
        end
        st_d.owner = win;
        if (tie && TIE_ALTERNATE) st_d.tie_right = !st_q.tie_right;
        lose_l = (win == OWN_RIGHT);
        lose_r = (win == OWN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{owner: OWN_NONE, tie_right: 1'b0};
        else        st_q <= st_d;
    end

    // R7: a fresh same-cycle arrival under fixed priority goes to the left port
    assert_tie_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!TIE_ALTERNATE && match && !$past(match) && !held_l && !held_r) |-> (lose_r && !lose_l));

    // R1: no loser without a collision
    assert_no_loser_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (!lose_l && !lose_r));
endmodule

// File: rtl/pca_wgate.sv
module pca_wgate (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic en,
    input  logic we,
    input  logic busy_int_n,
    input  logic busy_ext_n,
    output logic wr_ok
);
    logic ext_d, ext_q;
    logic pass;

    always_comb begin
        ext_d = busy_ext_n;
        pass  = master ? busy_int_n : (busy_ext_n && ext_q);
        wr_ok = en && we && pass;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_d;
    end

    // R5: no write from a port held off in master mode
    assert_no_wr_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !busy_int_n) |-> !wr_ok);

    // R9: slave write blocked while the incoming busy is low
    assert_slave_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !busy_ext_n) |-> !wr_ok);

    // R10: slave write needs the incoming busy high at the previous edge too
    assert_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !$past(busy_ext_n)) |-> !wr_ok);
endmodule

// File: rtl/port_collision_arb.sv
module port_collision_arb
    import pca_pkg::*;
#(
    parameter int AW            = 12,
    parameter bit TIE_ALTERNATE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_master,
    input  logic          left_en,
    input  logic          left_we,
    input  logic [AW-1:0] left_addr,
    input  logic          right_en,
    input  logic          right_we,
    input  logic [AW-1:0] right_addr,
    input  logic          left_busy_in_n,
    input  logic          right_busy_in_n,
    output logic          left_busy_n,
    output logic          right_busy_n,
    output logic          left_wr_ok,
    output logic          right_wr_ok
);
    localparam int NPORT = 2;

    logic [NPORT-1:0] en_v, we_v, held_v, lose_v, bint_v, bext_v, wok_v;
    logic [AW-1:0]    addr_v [NPORT];
    logic             match;

    always_comb begin
        en_v      = {right_en, left_en};
        we_v      = {right_we, left_we};
        addr_v[0] = left_addr;
        addr_v[1] = right_addr;
        bext_v    = {right_busy_in_n, left_busy_in_n};
        match     = left_en && right_en && (left_addr == right_addr);
        bint_v    = ~lose_v;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pca_port_track #(.AW(AW)) trk_i (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en_v[p]),
            .addr (addr_v[p]),
            .held (held_v[p])
        );
        pca_wgate wg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .master    (mode_master),
            .en        (en_v[p]),
            .we        (we_v[p]),
            .busy_int_n(bint_v[p]),
            .busy_ext_n(bext_v[p]),
            .wr_ok     (wok_v[p])
        );
    end

    pca_resolve #(.TIE_ALTERNATE(TIE_ALTERNATE)) res_i (
        .clk   (clk),
        .rst_n (rst_n),
        .match (match),
        .held_l(held_v[0]),
        .held_r(held_v[1]),
        .lose_l(lose_v[0]),
        .lose_r(lose_v[1])
    );

    always_comb begin
        left_busy_n  = mode_master ? bint_v[0] : 1'b1;
        right_busy_n = mode_master ? bint_v[1] : 1'b1;
        left_wr_ok   = wok_v[0];
        right_wr_ok  = wok_v[1];
    end

    // R4: exactly one busy low during a master-mode collision
    assert_one_loser_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && match) |-> (left_busy_n != right_busy_n));

    // R1: busy released whenever no collision exists
    assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (left_busy_n && right_busy_n));

    // R6: flags steady while a collision persists
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && $past(match) && mode_master && $past(mode_master) && $past(rst_n))
        |-> ($stable(left_busy_n) && $stable(right_busy_n)));

    // R8: slave never drives busy
    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |-> (left_busy_n && right_busy_n));
endmodule

// File: tb/port_collision_arb_tb.sv
module port_collision_arb_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_master;
    logic          left_en, left_we, right_en, right_we;
    logic [AW-1:0] left_addr, right_addr;
    logic          left_busy_in_n, right_busy_in_n;
    logic          left_busy_n, right_busy_n, left_wr_ok, right_wr_ok;
    logic          alt_left_busy_n, alt_right_busy_n, alt_left_wr_ok, alt_right_wr_ok;

    always #4 clk = ~clk;

    port_collision_arb #(.AW(AW), .TIE_ALTERNATE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .left_en(left_en), .left_we(left_we), .left_addr(left_addr),
        .right_en(right_en), .right_we(right_we), .right_addr(right_addr),
        .left_busy_in_n(left_busy_in_n), .right_busy_in_n(right_busy_in_n),
        .left_busy_n(left_busy_n), .right_busy_n(right_busy_n),
        .left_wr_ok(left_wr_ok), .right_wr_ok(right_wr_ok)
    );

    port_collision_arb #(.AW(AW), .TIE_ALTERNATE(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master),
        .left_en(left_en), .left_we(left_we), .left_addr(left_addr),
        .right_en(right_en), .right_we(right_we), .right_addr(right_addr),
        .left_busy_in_n(left_busy_in_n), .right_busy_in_n(right_busy_in_n),
        .left_busy_n(alt_left_busy_n), .right_busy_n(alt_right_busy_n),
        .left_wr_ok(alt_left_wr_ok), .right_wr_ok(alt_right_wr_ok)
    );

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    localparam logic [AW-1:0] A_ADDR = 12'h123;
    localparam logic [AW-1:0] B_ADDR = 12'h124;
    localparam logic [AW-1:0] C_ADDR = 12'h923;

    // exp bits: {left_busy_n, right_busy_n, left_wr_ok, right_wr_ok, alt_left_busy_n, alt_right_busy_n}
    task automatic step(input logic m,
                        input logic le, input logic lw, input logic [AW-1:0] la,
                        input logic re, input logic rw, input logic [AW-1:0] ra,
                        input logic bli, input logic bri,
                        input logic [5:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        mode_master = m;
        left_en = le; left_we = lw; left_addr = la;
        right_en = re; right_we = rw; right_addr = ra;
        left_busy_in_n = bli; right_busy_in_n = bri;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        logic [5:0] got;
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                got = {left_busy_n, right_busy_n, left_wr_ok, right_wr_ok,
                       alt_left_busy_n, alt_right_busy_n};
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s got %b expected %b", it.tag, got, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0;
        mode_master = 1'b1;
        left_en = 0; left_we = 0; left_addr = '0;
        right_en = 0; right_we = 0; right_addr = '0;
        left_busy_in_n = 1; right_busy_in_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R1 reset idle");
        step(1, 1,1,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_10_11, "R5 lone left write");
        step(1, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b10_10_10, "R2 R3 left first on enable");
        step(1, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b10_10_10, "R6 owner held");
        step(1, 1,0,A_ADDR, 1,1,A_ADDR, 1,1, 6'b10_00_10, "R5 loser write blocked");
        step(1, 1,1,A_ADDR, 0,1,A_ADDR, 1,1, 6'b11_10_11, "R1 release on disable");
        step(1, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R1 idle");
        step(1, 0,0,A_ADDR, 1,1,A_ADDR, 1,1, 6'b11_01_11, "R5 lone right write");
        step(1, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b01_01_01, "R2 right first");
        step(1, 1,1,B_ADDR, 1,1,A_ADDR, 1,1, 6'b11_11_11, "R1 address differs");
        step(1, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R1 idle");
        step(1, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b10_10_10, "R4 R7 first tie left");
        step(1, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R1 idle");
        step(1, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b10_10_01, "R7 second tie alternates");
        step(1, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b10_10_01, "R6 tie owner held");
        step(1, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R1 idle");
        step(1, 1,1,A_ADDR, 1,1,C_ADDR, 1,1, 6'b11_11_11, "R1 msb differs");
        step(1, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b10_10_10, "R3 address moves onto match");
        step(1, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R1 idle");
        step(0, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R8 slave idle");
        step(0, 1,1,A_ADDR, 1,1,B_ADDR, 0,1, 6'b11_01_11, "R9 slave busy in low");
        step(0, 1,1,A_ADDR, 1,1,B_ADDR, 1,1, 6'b11_01_11, "R10 slave settle cycle");
        step(0, 1,1,A_ADDR, 1,1,B_ADDR, 1,1, 6'b11_11_11, "R10 slave settled");
        step(0, 1,1,A_ADDR, 1,1,A_ADDR, 1,1, 6'b11_11_11, "R8 slave collision quiet");
        step(0, 0,0,A_ADDR, 0,0,A_ADDR, 1,1, 6'b11_00_11, "R8 slave idle");
        step(1, 1,1,A_ADDR, 0,0,A_ADDR, 0,0, 6'b11_10_11, "R11 master ignores busy in");
        step(1, 0,1,A_ADDR, 0,1,A_ADDR, 0,0, 6'b11_00_11, "R5 no enable no write");

        repeat (4) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule